// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Initialization Scheduler

This block owns the refresh duties of one EDO DRAM bank. Out of reset it keeps every strobe idle for a fixed settling pause. It then runs a fixed burst of CAS-before-RAS refresh cycles on its own, because no access may happen before the burst ends. After the burst it raises `init_done` and enters normal operation.

In normal operation an interval divider adds one owed refresh per refresh period to a saturating backlog counter. While refreshes are owed and no refresh cycle is running, the block asks the access sequencer for the shared RAS/CAS bus through `ref_req`. It starts a refresh only on a cycle where `ref_gnt` is high. Each refresh drives CAS low first, then RAS, releases both together, and ends with a precharge gap. Write enable stays inactive (high) and the address bus stays at zero throughout. Each finished refresh removes one entry from the backlog.

Every timing value is a parameter counted in clock cycles, so the same RTL fits any clock rate and speed grade.

Top module: `dram_ref_sched`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `ras_n`, `cas_n` and `we_n` are 1, `addr` is 0, and `init_done`, `ref_req`, `acc_allow` and `owed_cnt` are 0.
- R2: Both strobes stay high during the power-up pause. The first falling edge of `cas_n` appears right after clock edge PAUSE_CYC+1, counted from reset release.
- R3: In each refresh, `cas_n` falls while `ras_n` is high, exactly CSR_CYC cycles before `ras_n` falls. `cas_n` stays low for the whole time `ras_n` is low, and both rise on the same edge.
- R4: `ras_n` stays low for exactly RAS_CYC cycles. After RAS rises, both strobes stay high for at least RP_CYC cycles before the next CAS fall.
- R5: `we_n` is 1 and `addr` is 0 on every cycle, including while a refresh is running.
- R6: After the pause, exactly INIT_REFRESHES refresh cycles run with no grant. `init_done` rises on the edge after the last of them completes, and it never falls until reset.
- R7: With no grant, `owed_cnt` equals floor(j / INTERVAL_CYC), where j counts the clock edges since `init_done` rose.
- R8: `owed_cnt` saturates at BACKLOG_MAX and never exceeds it.
- R9: `ref_req` is high only when `init_done` is 1, `owed_cnt` is non-zero and no refresh cycle is running or just finishing. A refresh in normal operation starts only on an edge where `ref_gnt` is 1. With `ref_gnt` low, no refresh runs.
- R10: Each completed refresh in normal operation lowers `owed_cnt` by one. With `ref_gnt` held high, the backlog plus any periods that elapse during draining are all refreshed, and `owed_cnt` returns to 0.
- R11: `bus_own` is 1 while either strobe is low. `acc_allow` is 1 only when `init_done` is 1 and `bus_own` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_gnt | input | 1 | Sequencer yields the bus for a refresh |
| ref_req | output | 1 | Refresh owed; asks for the bus |
| bus_own | output | 1 | Block is driving the strobes |
| acc_allow | output | 1 | Sequencer may run accesses |
| init_done | output | 1 | Pause and initial burst complete |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held inactive (high) |
| addr | output | ADDR_W | Address bus, driven to zero |
| owed_cnt | output | OWED_W | Refreshes currently owed |

## Verification
The bench builds the block with a 20-cycle pause, the full 8-cycle initial burst, a 40-cycle refresh period, a 2/3/2-cycle CAS lead, RAS low time and precharge, and a backlog limit of 3. A few hundred cycles are then enough to cover the whole pause, every cycle of the init burst, saturation of the backlog after five ungranted periods, and a drain that overlaps a fresh period tick. Expected backlog values and refresh counts are computed as floor and min expressions over the cycle count.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_CAS,
    SEQ_RAS,
    SEQ_PRE
  } seq_state_e;

  typedef enum logic [1:0] {
    PH_PAUSE,
    PH_BURST,
    PH_RUN
  } phase_e;

  function automatic int cnt_width(input int limit);
    return (limit > 1) ? $clog2(limit) : 1;
  endfunction

endpackage

// File: rtl/dram_ref_div.sv
module dram_ref_div #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  import dram_ref_pkg::*;

  localparam int CW = cnt_width(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign tick = en && (cnt == LAST);

endmodule

// File: rtl/dram_ref_cbr_seq.sv
module dram_ref_cbr_seq #(
  parameter int CSR_CYC = 2,
  parameter int RAS_CYC = 7,
  parameter int RP_CYC  = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic ras_n,
  output logic cas_n,
  output logic busy,
  output logic done
);
  import dram_ref_pkg::*;

  localparam int MAX_AB = (CSR_CYC > RAS_CYC) ? CSR_CYC : RAS_CYC;
  localparam int MAXC   = (MAX_AB > RP_CYC) ? MAX_AB : RP_CYC;
  localparam int CW     = cnt_width(MAXC);
  localparam logic [CW-1:0] CSR_LD = CW'(CSR_CYC - 1);
  localparam logic [CW-1:0] RAS_LD = CW'(RAS_CYC - 1);
  localparam logic [CW-1:0] RP_LD  = CW'(RP_CYC - 1);

  seq_state_e    state;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SEQ_IDLE;
      cnt   <= '0;
      ras_n <= 1'b1;
      cas_n <= 1'b1;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        SEQ_IDLE: begin
          if (start) begin
            state <= SEQ_CAS;
            cas_n <= 1'b0;
            busy  <= 1'b1;
            cnt   <= CSR_LD;
          end
        end
        SEQ_CAS: begin
          if (cnt == '0) begin
            state <= SEQ_RAS;
            ras_n <= 1'b0;
            cnt   <= RAS_LD;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        SEQ_RAS: begin
          if (cnt == '0) begin
            state <= SEQ_PRE;
            ras_n <= 1'b1;
            cas_n <= 1'b1;
            cnt   <= RP_LD;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        SEQ_PRE: begin
          if (cnt == '0) begin
            state <= SEQ_IDLE;
            busy  <= 1'b0;
            done  <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dram_ref_backlog.sv
module dram_ref_backlog #(
  parameter int MAX_OWED = 8,
  parameter int W        = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         dec,
  output logic [W-1:0] owed
);
  localparam logic [W-1:0] CAP = W'(MAX_OWED);

  always_ff @(posedge clk) begin
    if (rst) begin
      owed <= '0;
    end else begin
      case ({inc, dec})
        2'b10:   if (owed != CAP) owed <= owed + 1'b1;
        2'b01:   if (owed != '0)  owed <= owed - 1'b1;
        default: owed <= owed;
      endcase
    end
  end

endmodule

// File: rtl/dram_ref_sched.sv
module dram_ref_sched #(
  parameter int PAUSE_CYC      = 25000,
  parameter int INIT_REFRESHES = 8,
  parameter int INTERVAL_CYC   = 1950,
  parameter int CSR_CYC        = 2,
  parameter int RAS_CYC        = 7,
  parameter int RP_CYC         = 4,
  parameter int BACKLOG_MAX    = 8,
  parameter int ADDR_W         = 12,
  localparam int OWED_W        = $clog2(BACKLOG_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_gnt,
  output logic              ref_req,
  output logic              bus_own,
  output logic              acc_allow,
  output logic              init_done,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [OWED_W-1:0] owed_cnt
);
  import dram_ref_pkg::*;

  localparam int IW = $clog2(INIT_REFRESHES + 1);
  localparam logic [IW-1:0] INIT_LAST = IW'(INIT_REFRESHES - 1);

  phase_e        phase;
  logic [IW-1:0] init_cnt;
  logic          pause_tick;
  logic          period_tick;
  logic          seq_busy;
  logic          seq_done;
  logic          seq_free;
  logic          start;
  logic          in_run;

  assign in_run   = (phase == PH_RUN);
  assign seq_free = !seq_busy && !seq_done;
  assign start    = seq_free &&
                    ((phase == PH_BURST) || (in_run && (owed_cnt != '0) && ref_gnt));

  dram_ref_div #(.LIMIT(PAUSE_CYC)) u_pause (
    .clk  (clk),
    .rst  (rst),
    .en   (phase == PH_PAUSE),
    .tick (pause_tick)
  );

  dram_ref_div #(.LIMIT(INTERVAL_CYC)) u_period (
    .clk  (clk),
    .rst  (rst),
    .en   (in_run),
    .tick (period_tick)
  );

  dram_ref_backlog #(.MAX_OWED(BACKLOG_MAX), .W(OWED_W)) u_owed (
    .clk  (clk),
    .rst  (rst),
    .inc  (period_tick),
    .dec  (seq_done && in_run),
    .owed (owed_cnt)
  );

  dram_ref_cbr_seq #(.CSR_CYC(CSR_CYC), .RAS_CYC(RAS_CYC), .RP_CYC(RP_CYC)) u_seq (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .busy  (seq_busy),
    .done  (seq_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_PAUSE;
      init_cnt  <= '0;
      init_done <= 1'b0;
    end else begin
      case (phase)
        PH_PAUSE: if (pause_tick) phase <= PH_BURST;
        PH_BURST: begin
          if (seq_done) begin
            if (init_cnt == INIT_LAST) begin
              phase     <= PH_RUN;
              init_done <= 1'b1;
            end else begin
              init_cnt <= init_cnt + 1'b1;
            end
          end
        end
        default: phase <= PH_RUN;
      endcase
    end
  end

  assign ref_req   = in_run && (owed_cnt != '0) && seq_free;
  assign bus_own   = seq_busy;
  assign acc_allow = init_done && !seq_busy;
  assign we_n      = 1'b1;
  assign addr      = '0;

endmodule

// File: rtl/dram_ref_sched_chk.sv
module dram_ref_sched_chk #(
  parameter int BACKLOG_MAX = 8,
  parameter int OWED_W      = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              ras_n,
  input logic              cas_n,
  input logic              ref_gnt,
  input logic              ref_req,
  input logic              init_done,
  input logic              bus_own,
  input logic [OWED_W-1:0] owed_cnt
);

  assert_cas_leads_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(cas_n) |-> ras_n);

  assert_ras_under_cas_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |-> (!cas_n && !$past(cas_n)));

  assert_joint_release_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(ras_n) |-> $rose(cas_n));

  assert_owed_cap_R8: assert property (@(posedge clk) disable iff (rst)
    owed_cnt <= OWED_W'(BACKLOG_MAX));

  assert_req_after_init_R9: assert property (@(posedge clk) disable iff (rst)
    ref_req |-> init_done);

  assert_start_granted_R9: assert property (@(posedge clk) disable iff (rst)
    ($fell(cas_n) && init_done) |-> $past(ref_gnt));

  assert_init_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);

  assert_strobes_owned_R11: assert property (@(posedge clk) disable iff (rst)
    (!ras_n || !cas_n) |-> bus_own);

endmodule

bind dram_ref_sched dram_ref_sched_chk #(
  .BACKLOG_MAX (BACKLOG_MAX),
  .OWED_W      (OWED_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ras_n     (ras_n),
  .cas_n     (cas_n),
  .ref_gnt   (ref_gnt),
  .ref_req   (ref_req),
  .init_done (init_done),
  .bus_own   (bus_own),
  .owed_cnt  (owed_cnt)
);

// File: tb/dram_ref_sched_test.sv
module dram_ref_sched_test;
  localparam int PAUSE = 20;
  localparam int INIT  = 8;
  localparam int INTV  = 40;
  localparam int CSR   = 2;
  localparam int RASC  = 3;
  localparam int RP    = 2;
  localparam int MAXO  = 3;
  localparam int AW    = 12;
  localparam int OW    = $clog2(MAXO + 1);

  logic          clk = 1'b0;
  logic          rst;
  logic          ref_gnt;
  logic          ref_req, bus_own, acc_allow, init_done, ras_n, cas_n, we_n;
  logic [AW-1:0] addr;
  logic [OW-1:0] owed_cnt;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dram_ref_sched #(
    .PAUSE_CYC(PAUSE), .INIT_REFRESHES(INIT), .INTERVAL_CYC(INTV),
    .CSR_CYC(CSR), .RAS_CYC(RASC), .RP_CYC(RP), .BACKLOG_MAX(MAXO), .ADDR_W(AW)
  ) uut (
    .clk(clk), .rst(rst), .ref_gnt(ref_gnt), .ref_req(ref_req), .bus_own(bus_own),
    .acc_allow(acc_allow), .init_done(init_done), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .addr(addr), .owed_cnt(owed_cnt)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // strobe monitor
  int  n = 0, ras_falls = 0, lead = 0, low_run = 0, hi_run = 0, cas_gap = 0;
  bit  prev_ras = 1, prev_cas = 1, first_seen = 0;

  always @(negedge clk) begin
    if (rst) begin
      n = 0; prev_ras = 1; prev_cas = 1;
    end else begin
      n++;
      if (prev_cas && !cas_n) begin
        chk(ras_n == 1'b1, "R3 cas falls while ras high", int'(ras_n), 1);
        if (!first_seen) begin
          chk(n == PAUSE + 1, "R2 first cas fall edge", n, PAUSE + 1);
          first_seen = 1;
        end else begin
          chk(hi_run >= RP, "R4 precharge before next cas fall", hi_run, RP);
        end
        lead = 0;
      end
      if (!cas_n && ras_n) lead++;
      if (prev_ras && !ras_n) begin
        chk(lead == CSR, "R3 cas lead cycles", lead, CSR);
        chk(we_n == 1'b1 && addr == '0, "R5 we high addr zero", int'(addr), 0);
        chk(bus_own && !acc_allow, "R11 bus owned during refresh", int'(acc_allow), 0);
        ras_falls++;
        low_run = 0;
      end
      if (!ras_n) begin
        low_run++;
        if (cas_n) cas_gap++;
      end
      if (!prev_ras && ras_n) begin
        chk(low_run == RASC, "R4 ras low cycles", low_run, RASC);
        chk(cas_n && cas_gap == 0, "R3 cas held through ras low", cas_gap, 0);
        cas_gap = 0;
        hi_run = 0;
      end
      if (ras_n && cas_n) hi_run++;
      prev_ras = ras_n;
      prev_cas = cas_n;
    end
  end

  int j = 0;
  task automatic go_to(input int target);
    while (j < target) begin
      @(negedge clk); #1;
      j++;
    end
  endtask

  initial begin
    rst = 1'b1;
    ref_gnt = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(ras_n && cas_n && we_n, "R1 strobes idle in reset", int'({ras_n, cas_n, we_n}), 7);
    chk(!init_done && !ref_req && !acc_allow, "R1 flags low in reset",
        int'({init_done, ref_req, acc_allow}), 0);
    chk(owed_cnt == '0 && addr == '0, "R1 counters zero in reset", int'(owed_cnt), 0);
    rst = 1'b0;
    @(negedge clk); #1;
    chk(ras_n && cas_n && !init_done, "R1 idle after release", int'({ras_n, cas_n}), 3);
    repeat (PAUSE - 2) @(negedge clk);
    #1;
    chk(ras_n && cas_n && !acc_allow, "R2 strobes idle late in pause",
        int'({ras_n, cas_n, acc_allow}), 6);
    while (!init_done) begin
      @(negedge clk); #1;
    end
    chk(ras_falls == INIT, "R6 init burst length", ras_falls, INIT);
    chk(acc_allow == 1'b1, "R11 access allowed after init", int'(acc_allow), 1);
    chk(ras_n && cas_n, "R6 burst finished at init_done", int'({ras_n, cas_n}), 3);

    for (int k = 0; k <= 5; k++) begin
      int e;
      go_to(k * INTV + INTV / 2);
      e = (k < MAXO) ? k : MAXO;
      chk(owed_cnt == OW'(e), "R7 R8 owed count without grant", int'(owed_cnt), e);
      chk(ref_req == (k > 0), "R9 request level", int'(ref_req), int'(k > 0));
      chk(ras_falls == INIT, "R9 no refresh without grant", ras_falls, INIT);
      chk(init_done == 1'b1, "R6 init_done stays high", int'(init_done), 1);
    end

    ref_gnt = 1'b1;
    go_to(6 * INTV + INTV / 2);
    chk(ras_falls == INIT + MAXO + 1, "R10 drain plus overlapping tick",
        ras_falls, INIT + MAXO + 1);
    chk(owed_cnt == '0, "R10 backlog empty after drain", int'(owed_cnt), 0);
    chk(!ref_req, "R9 request drops when nothing owed", int'(ref_req), 0);

    for (int k = 7; k <= 9; k++) begin
      go_to(k * INTV + INTV / 2);
      chk(ras_falls == INIT + MAXO + 1 + (k - 6), "R10 one refresh per period",
          ras_falls, INIT + MAXO + 1 + (k - 6));
      chk(owed_cnt == '0 && acc_allow, "R10 R11 idle between periods", int'(owed_cnt), 0);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule